// File: doc/BRIEF.md
# Register Window Occupancy Controller

This block tracks how the windows of a rotating register file are in use, for a processor that stacks register windows on procedure entry and exit. It holds four occupancy counters (free-to-save, restorable, windows belonging to another context, and windows already cleaned), a six-bit trap-vector selector and the current window pointer. Each is sized from the parameter `NWIN`. A one-cycle command asks the block to enter a new window, leave one, flush all windows, or tell it that a spill or a fill handler has finished.

Each command either updates the counters and the pointer, or it leaves all state as it was and raises a one-cycle trap request carrying a nine-bit trap type. Software can write any counter, the selector or the window pointer through a small select/data port. It reads them back through a registered read port. The pointer is shown to software in reversed order.

Top module: `win_occ_ctrl`

## Requirements
- R1: After reset, free-to-save reads NWIN-2, restorable reads 0, other reads 0, clean reads NWIN-1, the selector reads 0 and the software pointer reads NWIN-1. `trap_valid` is low.
- R2: Enter (cmd_op=1) with free-to-save equal to 0 raises a spill trap.
- R3: Enter with free-to-save nonzero and clean equal to restorable raises trap type 0x024.
- R4: Enter that does not trap decrements free-to-save, increments restorable and adds one, modulo NWIN, to the software pointer.
- R5: Leave (cmd_op=2) with restorable equal to 0 raises a fill trap. Otherwise it increments free-to-save, decrements restorable and subtracts one, modulo NWIN, from the software pointer.
- R6: A spill trap type is 0x080 and a fill trap type is 0x0C0, each ORed with a term. When other is zero, the term is selector bits [2:0] shifted left by 2. When other is nonzero, it is 0x020 ORed with selector bits [5:3] shifted left by 2.
- R7: Flush (cmd_op=3) raises a spill trap, coded as in R6, unless free-to-save equals NWIN-2. When free-to-save equals NWIN-2 it changes nothing.
- R8: Spilled (cmd_op=4) increments free-to-save. It then decrements restorable if other is 0, and decrements other if it is not.
- R9: Filled (cmd_op=5) increments restorable. It increments clean only while clean is below NWIN-1. It then decrements free-to-save if other is 0, and decrements other if it is not.
- R10: The software pointer equals NWIN-1 minus the internal pointer. A written value is reduced modulo NWIN.
- R11: A trapping command leaves every counter, the selector and the pointer unchanged. `trap_valid` is high for exactly the cycle after the command's clock edge.
- R12: Write selects are 0 free-to-save, 1 restorable, 2 other, 3 clean, 4 selector and 5 software pointer. A write in the same cycle as a command is ignored. `rd_data` shows the selected item one cycle after `rd_sel` is set. Selects 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command code (1 enter, 2 leave, 3 flush, 4 spilled, 5 filled) |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 3 | Item to write |
| wr_data | input | DW | Write value |
| rd_sel | input | 3 | Item to read |
| rd_data | output | DW | Registered read value |
| trap_valid | output | 1 | Trap request, one cycle |
| trap_type | output | 9 | Trap type code |

## Verification
The cases that are hardest to reach from the ports are a trap whose type depends on the other counter together with selector fields, and the clean-window trap, which needs free-to-save nonzero while clean equals restorable. Reset never gives that combination, and normal enter/leave sequences reach it only slowly. The bench therefore uses software writes to load each counter combination directly. It then issues a single command, checks the trap type, and reads every counter back to confirm that nothing moved. The clean-counter saturation and the rule that a write loses to a same-cycle command are set up in the same way.

// File: rtl/winocc_pkg.sv
package winocc_pkg;
  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_ENTER    = 3'd1,
    OP_LEAVE    = 3'd2,
    OP_FLUSH    = 3'd3,
    OP_SPILLED  = 3'd4,
    OP_FILLED   = 3'd5
  } occ_op_e;

  typedef enum logic [2:0] {
    SEL_FREE    = 3'd0,
    SEL_RESTORE = 3'd1,
    SEL_OTHER   = 3'd2,
    SEL_CLEAN   = 3'd3,
    SEL_VECSEL  = 3'd4,
    SEL_PTR     = 3'd5
  } occ_sel_e;

  localparam logic [8:0] TT_SPILL_BASE = 9'h080;
  localparam logic [8:0] TT_FILL_BASE  = 9'h0C0;
  localparam logic [8:0] TT_OTHER_FLAG = 9'h020;
  localparam logic [8:0] TT_CLEAN      = 9'h024;
endpackage

// File: rtl/winocc_trapcode.sv
module winocc_trapcode
  import winocc_pkg::*;
(
  input  logic       other_nz,
  input  logic [5:0] vecsel,
  output logic [8:0] spill_code,
  output logic [8:0] fill_code
);
  logic [8:0] term;

  always_comb begin
    if (other_nz)
      term = TT_OTHER_FLAG | {4'd0, vecsel[5:3], 2'b00};
    else
      term = {4'd0, vecsel[2:0], 2'b00};
  end

  assign spill_code = TT_SPILL_BASE | term;
  assign fill_code  = TT_FILL_BASE | term;
endmodule

// File: rtl/winocc_core.sv
module winocc_core
  import winocc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [8:0]    spill_code,
  input  logic [8:0]    fill_code,
  output logic [CW-1:0] free_q,
  output logic [CW-1:0] rest_q,
  output logic [CW-1:0] other_q,
  output logic [CW-1:0] clean_q,
  output logic [5:0]    vecsel_q,
  output logic [CW-1:0] ptr_q,
  output logic          trap_q,
  output logic [8:0]    ttype_q
);
  localparam logic [CW-1:0] FREE_FULL = CW'(NWIN - 2);
  localparam logic [CW-1:0] TOP       = CW'(NWIN - 1);

  logic [CW-1:0] free_n, rest_n, other_n, clean_n, ptr_n;
  logic [5:0]    vecsel_n;
  logic          trap_n;
  logic [8:0]    ttype_n;
  occ_op_e       op;

  assign op = occ_op_e'(cmd_op);

  function automatic logic [CW-1:0] ptr_from_sw(input logic [DW-1:0] v);
    int unsigned m;
    m = int'(v) % NWIN;
    return CW'(NWIN - 1 - m);
  endfunction

  function automatic logic [CW-1:0] ptr_up(input logic [CW-1:0] p);
    return (p == TOP) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CW-1:0] ptr_down(input logic [CW-1:0] p);
    return (p == '0) ? TOP : p - 1'b1;
  endfunction

  always_comb begin
    free_n   = free_q;
    rest_n   = rest_q;
    other_n  = other_q;
    clean_n  = clean_q;
    vecsel_n = vecsel_q;
    ptr_n    = ptr_q;
    trap_n   = 1'b0;
    ttype_n  = ttype_q;
    if (cmd_valid) begin
      case (op)
        OP_ENTER: begin
          if (free_q == '0) begin
            trap_n  = 1'b1;
            ttype_n = spill_code;
          end else if (clean_q == rest_q) begin
            trap_n  = 1'b1;
            ttype_n = TT_CLEAN;
          end else begin
            free_n = free_q - 1'b1;
            rest_n = rest_q + 1'b1;
            ptr_n  = ptr_down(ptr_q);
          end
        end
        OP_LEAVE: begin
          if (rest_q == '0) begin
            trap_n  = 1'b1;
            ttype_n = fill_code;
          end else begin
            free_n = free_q + 1'b1;
            rest_n = rest_q - 1'b1;
            ptr_n  = ptr_up(ptr_q);
          end
        end
        OP_FLUSH: begin
          if (free_q != FREE_FULL) begin
            trap_n  = 1'b1;
            ttype_n = spill_code;
          end
        end
        OP_SPILLED: begin
          free_n = free_q + 1'b1;
          if (other_q == '0) rest_n = rest_q - 1'b1;
          else               other_n = other_q - 1'b1;
        end
        OP_FILLED: begin
          rest_n = rest_q + 1'b1;
          if (clean_q < TOP) clean_n = clean_q + 1'b1;
          if (other_q == '0) free_n = free_q - 1'b1;
          else               other_n = other_q - 1'b1;
        end
        default: ;
      endcase
    end else if (wr_en) begin
      case (occ_sel_e'(wr_sel))
        SEL_FREE:    free_n   = CW'(wr_data);
        SEL_RESTORE: rest_n   = CW'(wr_data);
        SEL_OTHER:   other_n  = CW'(wr_data);
        SEL_CLEAN:   clean_n  = CW'(wr_data);
        SEL_VECSEL:  vecsel_n = wr_data[5:0];
        SEL_PTR:     ptr_n    = ptr_from_sw(wr_data);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q   <= FREE_FULL;
      rest_q   <= '0;
      other_q  <= '0;
      clean_q  <= TOP;
      vecsel_q <= '0;
      ptr_q    <= '0;
      trap_q   <= 1'b0;
      ttype_q  <= '0;
    end else begin
      free_q   <= free_n;
      rest_q   <= rest_n;
      other_q  <= other_n;
      clean_q  <= clean_n;
      vecsel_q <= vecsel_n;
      ptr_q    <= ptr_n;
      trap_q   <= trap_n;
      ttype_q  <= ttype_n;
    end
  end

  // R11
  trap_holds_state_chk: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> ($stable(free_q) && $stable(rest_q) && $stable(other_q) &&
                $stable(clean_q) && $stable(ptr_q)));

  // R11
  trap_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !trap_q);

  // R6
  trap_code_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    trap_q |-> (ttype_q[1:0] == 2'b00 && ttype_q[8] == 1'b0));

  // R4
  enter_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd1 && free_q != '0 && clean_q != rest_q)
      |=> (rest_q == $past(rest_q) + 1'b1 && !trap_q));

  // R9
  clean_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd5 && clean_q == TOP) |=> (clean_q == TOP));

  // R5
  leave_empty_traps_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && rest_q == '0) |=> trap_q);
endmodule

// File: rtl/winocc_readback.sv
module winocc_readback
  import winocc_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    rd_sel,
  input  logic [CW-1:0] free_q,
  input  logic [CW-1:0] rest_q,
  input  logic [CW-1:0] other_q,
  input  logic [CW-1:0] clean_q,
  input  logic [5:0]    vecsel_q,
  input  logic [CW-1:0] ptr_q,
  output logic [DW-1:0] rd_data
);
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);
  logic [DW-1:0] mux;

  always_comb begin
    case (occ_sel_e'(rd_sel))
      SEL_FREE:    mux = DW'(free_q);
      SEL_RESTORE: mux = DW'(rest_q);
      SEL_OTHER:   mux = DW'(other_q);
      SEL_CLEAN:   mux = DW'(clean_q);
      SEL_VECSEL:  mux = DW'(vecsel_q);
      SEL_PTR:     mux = DW'(TOP - ptr_q);
      default:     mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mux;
  end

  // R12
  unused_sel_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel[2:1] == 2'b11) |=> (rd_data == '0));
endmodule

// File: rtl/win_occ_ctrl.sv
module win_occ_ctrl #(
  parameter int NWIN = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          trap_valid,
  output logic [8:0]    trap_type
);
  localparam int CW = $clog2(NWIN);

  logic [CW-1:0] free_q, rest_q, other_q, clean_q, ptr_q;
  logic [5:0]    vecsel_q;
  logic [8:0]    spill_code, fill_code;

  winocc_trapcode u_code (
    .other_nz   (other_q != '0),
    .vecsel     (vecsel_q),
    .spill_code (spill_code),
    .fill_code  (fill_code)
  );

  winocc_core #(.NWIN(NWIN), .DW(DW)) u_core (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .spill_code (spill_code),
    .fill_code  (fill_code),
    .free_q     (free_q),
    .rest_q     (rest_q),
    .other_q    (other_q),
    .clean_q    (clean_q),
    .vecsel_q   (vecsel_q),
    .ptr_q      (ptr_q),
    .trap_q     (trap_valid),
    .ttype_q    (trap_type)
  );

  winocc_readback #(.NWIN(NWIN), .DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_sel   (rd_sel),
    .free_q   (free_q),
    .rest_q   (rest_q),
    .other_q  (other_q),
    .clean_q  (clean_q),
    .vecsel_q (vecsel_q),
    .ptr_q    (ptr_q),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/win_occ_ctrl_test.sv
module win_occ_ctrl_test;
  localparam int NWIN = 8;
  localparam int DW   = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_sel = '0;
  logic [DW-1:0] rd_data;
  logic          trap_valid;
  logic [8:0]    trap_type;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  win_occ_ctrl #(.NWIN(NWIN), .DW(DW)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .trap_valid(trap_valid), .trap_type(trap_type)
  );

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = DW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int sel, output int val);
    @(negedge clk);
    rd_sel = 3'(sel);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic cmd(input int op, output int tv, output int tt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'(op);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0;
    tv = int'(trap_valid); tt = int'(trap_type);
  endtask

  task automatic load(input int fr, input int re, input int ot, input int cl, input int vs);
    wr(0, fr); wr(1, re); wr(2, ot); wr(3, cl); wr(4, vs);
  endtask

  task automatic expect_state(input string req, input int fr, input int re, input int ot, input int cl);
    int v;
    rd(0, v); check({req, " free"}, v, fr);
    rd(1, v); check({req, " restorable"}, v, re);
    rd(2, v); check({req, " other"}, v, ot);
    rd(3, v); check({req, " clean"}, v, cl);
  endtask

  task automatic t_reset();
    int v;
    expect_state("R1", NWIN-2, 0, 0, NWIN-1);
    rd(4, v); check("R1 selector", v, 0);
    rd(5, v); check("R1 pointer", v, NWIN-1);
    check("R1 trap_valid", int'(trap_valid), 0);
  endtask

  task automatic t_enter_leave();
    int tv, tt, v;
    cmd(1, tv, tt); check("R4 no trap", tv, 0);
    expect_state("R4", 5, 1, 0, 7);
    rd(5, v); check("R4 pointer wraps", v, 0);
    cmd(2, tv, tt); check("R5 no trap", tv, 0);
    expect_state("R5", 6, 0, 0, 7);
    rd(5, v); check("R5 pointer", v, 7);
    cmd(2, tv, tt); check("R5 fill trap", tv, 1); check("R5 fill code", tt, 'h0C0);
    expect_state("R11 after fill", 6, 0, 0, 7);
    @(negedge clk); check("R11 one-cycle trap", int'(trap_valid), 0);
  endtask

  task automatic t_codes();
    int tv, tt;
    load(6, 0, 0, 7, 'h2B);
    cmd(2, tv, tt); check("R6 fill other=0", tt, 'h0CC);
    wr(2, 1);
    cmd(2, tv, tt); check("R6 fill other!=0", tt, 'h0F4);
    load(0, 3, 0, 7, 'h2B);
    cmd(1, tv, tt); check("R2 spill trap", tv, 1); check("R2 spill code", tt, 'h08C);
    expect_state("R11 after spill", 0, 3, 0, 7);
  endtask

  task automatic t_clean();
    int tv, tt, v;
    load(3, 2, 0, 2, 0);
    rd(5, v);
    begin
      int p0 = v;
      cmd(1, tv, tt); check("R3 trap", tv, 1); check("R3 code", tt, 'h024);
      expect_state("R11 after clean", 3, 2, 0, 2);
      rd(5, v); check("R11 pointer", v, p0);
    end
  endtask

  task automatic t_flush();
    int tv, tt;
    load(3, 0, 0, 7, 'h2B);
    cmd(3, tv, tt); check("R7 trap", tv, 1); check("R7 code", tt, 'h08C);
    wr(0, NWIN-2);
    cmd(3, tv, tt); check("R7 no trap", tv, 0);
    expect_state("R7", NWIN-2, 0, 0, 7);
  endtask

  task automatic t_spilled_filled();
    int tv, tt;
    load(2, 3, 0, 4, 0);
    cmd(4, tv, tt); expect_state("R8 other=0", 3, 2, 0, 4);
    wr(2, 2);
    cmd(4, tv, tt); expect_state("R8 other!=0", 4, 2, 1, 4);
    load(4, 1, 0, 5, 0);
    cmd(5, tv, tt); expect_state("R9 other=0", 3, 2, 0, 6);
    wr(3, 7);
    cmd(5, tv, tt); expect_state("R9 saturate", 2, 3, 0, 7);
    wr(2, 1);
    cmd(5, tv, tt); expect_state("R9 other!=0", 2, 4, 0, 7);
  endtask

  task automatic t_pointer();
    int tv, tt, v;
    wr(5, 10); rd(5, v); check("R10 modulo write", v, 2);
    wr(5, 3);  rd(5, v); check("R10 write", v, 3);
    load(4, 1, 0, 6, 0);
    cmd(1, tv, tt); rd(5, v); check("R10 enter step", v, 4);
  endtask

  task automatic t_collide();
    int v;
    load(2, 3, 0, 4, 0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd4;
    wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'd1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; wr_en = 1'b0;
    rd(0, v); check("R12 write loses to command", v, 3);
    rd(6, v); check("R12 unused select", v, 0);
    rd(4, v); check("R12 selector readback", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_enter_leave();
    t_codes();
    t_clean();
    t_flush();
    t_spilled_filled();
    t_pointer();
    t_collide();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule